// File: doc/BRIEF.md
# Shared-Generator Self-Test Group

This block wraps a group of identical arithmetic units, such as several adders, so that the whole group can test itself in one session. Two pseudo-random generators, one per operand, feed the same word to the matching operand of every unit. An equality comparator checks on every test cycle that all units return the same result. A single signature register compacts the result of unit 0 only. A fault in any unit therefore shows up as a comparator mismatch, a wrong signature, or both.

Software or a test controller chooses the pattern count, the generator seeds, the signature start value and the expected signature, and then pulses `start`. The block applies exactly that many patterns. In the following cycle it decides pass or fail. It then shifts the signature out serially, most significant bit first, which takes K cycles. The block then raises `done` and holds the verdict. When `test_en` is low, the units receive their functional operands unchanged.

Top module: `bist_group`

## Requirements
- R1: While `test_en` is 0, `mut_a` equals `func_a` and `mut_b` equals `func_b` bit for bit.
- R2: While `test_en` is 1, every K-bit slice of `mut_a` carries the same generator word, and the same holds for `mut_b`. Each generator starts from its seed when a test is accepted and advances once per applied pattern. The next value is (word shifted left by one, truncated to K bits) XOR (feedback mask if the old top bit was 1). For K=8 the mask is 0x1D.
- R3: A seed of zero is loaded as the value 1, so a generator never sits in the all-zero state.
- R4: An accepted start applies exactly `test_len` patterns, one per clock. A length of 0 applies none, and the signature then keeps its start value.
- R5: The signature starts at `misr_init`. For each pattern it becomes (signature shifted left by one) XOR (mask if the old top bit was 1) XOR the result word of unit 0 (`mut_y[K-1:0]`), using the same mask as R2.
- R6: `mismatch` goes to 1 in the cycle after any pattern cycle in which the N result words are not all equal. It then stays at 1, even when later results agree, until the next accepted start clears it.
- R7: In the one cycle after the last pattern, `fail` is set to (`mismatch` OR signature ≠ `expect_sig`). During that cycle `busy` is 1 and `sig_valid` is 0.
- R8: After that cycle, `sig_valid` is 1 for exactly K cycles. During those cycles `sig_bit` presents the signature from bit K-1 down to bit 0.
- R9: After the unload, `done` is 1 and `busy` is 0. `done`, `fail` and `mismatch` hold until the next accepted start.
- R10: A `start` while `busy` is 1 is ignored, and the running test continues with an unchanged pattern count and signature.
- R11: After reset, `busy`, `done`, `mismatch`, `fail` and `sig_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | 1 selects generator operands, 0 passes functional operands |
| start | input | 1 | Pulse that begins a test when the block is idle or done |
| test_len | input | CW | Number of patterns to apply |
| seed_a | input | K | Start value of the operand-A generator |
| seed_b | input | K | Start value of the operand-B generator |
| misr_init | input | K | Start value of the signature register |
| expect_sig | input | K | Signature of a fault-free group |
| func_a | input | N*K | Functional operand A, one slice per unit |
| func_b | input | N*K | Functional operand B, one slice per unit |
| mut_a | output | N*K | Operand A driven to each unit |
| mut_b | output | N*K | Operand B driven to each unit |
| mut_y | input | N*K | Result word from each unit, unit 0 in the low slice |
| busy | output | 1 | Test is in progress |
| done | output | 1 | Test and unload are complete |
| mismatch | output | 1 | Sticky: the units disagreed at least once |
| fail | output | 1 | Verdict, meaningful while `done` is 1 |
| sig_bit | output | 1 | Serial signature bit |
| sig_valid | output | 1 | `sig_bit` carries a signature bit |

## Verification
The bench sweeps pattern counts from 0 upward with several seed pairs, including zero seeds. It checks each generator word and the serially unloaded signature against arithmetic models. A design that applied one pattern too many or too few, or that locked up on a zero seed, would unload a different signature.

A single-cycle fault injected into the last unit must leave the signature intact and still set a sticky `mismatch`. A design that cleared the flag when later results agreed would report a pass. Runs with a corrupted expected value must fail without any mismatch. A start pulse in the middle of a run must change nothing; a design that restarted on it would unload the wrong bits.

// File: rtl/bist_grp_pkg.sv
package bist_grp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_CHECK  = 3'd2,
    ST_UNLOAD = 3'd3,
    ST_DONE   = 3'd4
  } grp_state_e;

  // Feedback mask (low terms of a primitive polynomial) for a given width.
  function automatic logic [63:0] fb_mask(input int w);
    case (w)
      4:       fb_mask = 64'h3;
      8:       fb_mask = 64'h1D;
      16:      fb_mask = 64'h100B;
      32:      fb_mask = 64'h0040_0007;
      default: fb_mask = 64'h3;
    endcase
  endfunction

endpackage

// File: rtl/bist_prpg.sv
module bist_prpg #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [K-1:0] seed,
  input  logic         adv,
  output logic [K-1:0] q
);
  localparam logic [K-1:0] MASK = K'(bist_grp_pkg::fb_mask(K));

  logic [K-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)
      q_d = (seed == '0) ? K'(1) : seed;
    else if (adv)
      q_d = {q[K-2:0], 1'b0} ^ ({K{q[K-1]}} & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= K'(1);
    else        q <= q_d;
  end
endmodule

// File: rtl/bist_eqcmp.sv
module bist_eqcmp #(
  parameter int N = 3,
  parameter int K = 8
) (
  input  logic [N*K-1:0] words,
  output logic           all_eq
);
  logic [N-1:0] same;

  assign same[0] = 1'b1;
  for (genvar i = 1; i < N; i++) begin : g_cmp
    assign same[i] = (words[i*K +: K] == words[K-1:0]);
  end

  assign all_eq = &same;
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [K-1:0] init,
  input  logic         comp,
  input  logic [K-1:0] din,
  input  logic         shift,
  output logic [K-1:0] q
);
  localparam logic [K-1:0] MASK = K'(bist_grp_pkg::fb_mask(K));

  logic [K-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)
      q_d = init;
    else if (comp)
      q_d = {q[K-2:0], 1'b0} ^ ({K{q[K-1]}} & MASK) ^ din;
    else if (shift)
      q_d = {q[K-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/bist_group.sv
module bist_group
  import bist_grp_pkg::*;
#(
  parameter int N  = 3,
  parameter int K  = 8,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_en,
  input  logic            start,
  input  logic [CW-1:0]   test_len,
  input  logic [K-1:0]    seed_a,
  input  logic [K-1:0]    seed_b,
  input  logic [K-1:0]    misr_init,
  input  logic [K-1:0]    expect_sig,
  input  logic [N*K-1:0]  func_a,
  input  logic [N*K-1:0]  func_b,
  output logic [N*K-1:0]  mut_a,
  output logic [N*K-1:0]  mut_b,
  input  logic [N*K-1:0]  mut_y,
  output logic            busy,
  output logic            done,
  output logic            mismatch,
  output logic            fail,
  output logic            sig_bit,
  output logic            sig_valid
);
  localparam int NP = 2;
  localparam int SW = (K > 2) ? $clog2(K) : 1;

  grp_state_e        st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [SW-1:0]     sh_q, sh_d;
  logic              mis_q, mis_d;
  logic              fail_q, fail_d;
  logic              go, run, all_eq;
  logic [K-1:0]      sig;
  logic [NP-1:0][K-1:0] seeds, pats;
  logic [NP-1:0][N*K-1:0] funcs, outs;

  assign go  = start && (st_q == ST_IDLE || st_q == ST_DONE);
  assign run = (st_q == ST_RUN);

  assign seeds = {seed_b, seed_a};
  assign funcs = {func_b, func_a};

  for (genvar p = 0; p < NP; p++) begin : g_port
    bist_prpg #(.K(K)) u_gen (
      .clk  (clk),
      .rst_n(rst_n),
      .load (go),
      .seed (seeds[p]),
      .adv  (run),
      .q    (pats[p])
    );
    for (genvar i = 0; i < N; i++) begin : g_unit
      assign outs[p][i*K +: K] = test_en ? pats[p] : funcs[p][i*K +: K];
    end
  end

  assign mut_a = outs[0];
  assign mut_b = outs[1];

  bist_eqcmp #(.N(N), .K(K)) u_cmp (
    .words (mut_y),
    .all_eq(all_eq)
  );

  bist_misr #(.K(K)) u_sig (
    .clk  (clk),
    .rst_n(rst_n),
    .load (go),
    .init (misr_init),
    .comp (run),
    .din  (mut_y[K-1:0]),
    .shift(st_q == ST_UNLOAD),
    .q    (sig)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    mis_d  = mis_q;
    fail_d = fail_q;
    if (go) begin
      cnt_d  = test_len;
      mis_d  = 1'b0;
      fail_d = 1'b0;
      st_d   = (test_len == '0) ? ST_CHECK : ST_RUN;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (!all_eq) mis_d = 1'b1;
          cnt_d = cnt_q - CW'(1);
          if (cnt_q == CW'(1)) st_d = ST_CHECK;
        end
        ST_CHECK: begin
          fail_d = mis_q | (sig != expect_sig);
          sh_d   = SW'(K - 1);
          st_d   = ST_UNLOAD;
        end
        ST_UNLOAD: begin
          sh_d = sh_q - SW'(1);
          if (sh_q == '0) st_d = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      mis_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      mis_q  <= mis_d;
      fail_q <= fail_d;
    end
  end

  assign busy      = (st_q == ST_RUN) || (st_q == ST_CHECK) || (st_q == ST_UNLOAD);
  assign done      = (st_q == ST_DONE);
  assign mismatch  = mis_q;
  assign fail      = fail_q;
  assign sig_valid = (st_q == ST_UNLOAD);
  assign sig_bit   = sig_valid & sig[K-1];
endmodule

// File: rtl/bist_group_chk.sv
module bist_group_chk #(
  parameter int N  = 3,
  parameter int K  = 8,
  parameter int CW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           test_en,
  input logic           start,
  input logic [N*K-1:0] func_a,
  input logic [N*K-1:0] func_b,
  input logic [N*K-1:0] mut_a,
  input logic [N*K-1:0] mut_b,
  input logic           busy,
  input logic           done,
  input logic           mismatch,
  input logic           fail,
  input logic           sig_valid
);
  localparam int VW = $clog2(K + 2);
  logic [VW-1:0] vrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vrun <= '0;
    else if (sig_valid) vrun <= vrun + VW'(1);
    else                vrun <= '0;
  end

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (mut_a == func_a && mut_b == func_b)); // R1

  AST_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> (mut_a == {N{mut_a[K-1:0]}} && mut_b == {N{mut_b[K-1:0]}})); // R2

  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !(start && !busy)) |=> mismatch); // R6

  AST_UNLOAD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_valid && $past(sig_valid)) |-> (vrun == VW'(K))); // R8

  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail) && $stable(mismatch))); // R9

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && (busy || sig_valid))); // R9
endmodule

bind bist_group bist_group_chk #(.N(N), .K(K), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .test_en  (test_en),
  .start    (start),
  .func_a   (func_a),
  .func_b   (func_b),
  .mut_a    (mut_a),
  .mut_b    (mut_b),
  .busy     (busy),
  .done     (done),
  .mismatch (mismatch),
  .fail     (fail),
  .sig_valid(sig_valid)
);

// File: tb/bist_group_test.sv
`timescale 1ns/1ps
module bist_group_test;
  localparam int N  = 3;
  localparam int K  = 8;
  localparam int CW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            test_en, start, flt;
  logic [CW-1:0]   test_len;
  logic [K-1:0]    seed_a, seed_b, misr_init, expect_sig;
  logic [N*K-1:0]  func_a, func_b, mut_a, mut_b, mut_y;
  logic            busy, done, mismatch, fail, sig_bit, sig_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Units under test: adders, the last one with an injectable bit flip.
  for (genvar i = 0; i < N; i++) begin : g_add
    if (i == N - 1) begin : g_f
      assign mut_y[i*K +: K] = (mut_a[i*K +: K] + mut_b[i*K +: K]) ^ {{(K-1){1'b0}}, flt};
    end else begin : g_ok
      assign mut_y[i*K +: K] = mut_a[i*K +: K] + mut_b[i*K +: K];
    end
  end

  bist_group #(.N(N), .K(K), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .start(start),
    .test_len(test_len), .seed_a(seed_a), .seed_b(seed_b),
    .misr_init(misr_init), .expect_sig(expect_sig),
    .func_a(func_a), .func_b(func_b), .mut_a(mut_a), .mut_b(mut_b),
    .mut_y(mut_y), .busy(busy), .done(done), .mismatch(mismatch),
    .fail(fail), .sig_bit(sig_bit), .sig_valid(sig_valid)
  );

  function automatic logic [K-1:0] step(input logic [K-1:0] v);
    step = {v[K-2:0], 1'b0} ^ (v[K-1] ? 8'h1D : 8'h00);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One complete session; flt_idx < 0 means no fault, mid_start < 0 no extra start.
  task automatic run(input int len, input logic [K-1:0] sa, input logic [K-1:0] sb,
                     input logic [K-1:0] init, input bit good_exp,
                     input int flt_idx, input int mid_start);
    logic [K-1:0] a, b, m, fin;
    bit exp_mis;
    a = (sa == 0) ? 8'h01 : sa;
    b = (sb == 0) ? 8'h01 : sb;
    m = init;
    for (int p = 0; p < len; p++) begin
      m = step(m) ^ (a + b);
      a = step(a);
      b = step(b);
    end
    fin = m;
    exp_mis = (flt_idx >= 0) && (flt_idx < len);
    a = (sa == 0) ? 8'h01 : sa;
    b = (sb == 0) ? 8'h01 : sb;

    @(negedge clk);
    test_len = CW'(len); seed_a = sa; seed_b = sb; misr_init = init;
    expect_sig = good_exp ? fin : (fin ^ 8'h01);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mismatch == 1'b0, "R6 cleared by start", 32'(mismatch), 0);
    for (int p = 0; p < len; p++) begin
      chk(busy == 1'b1, "R4 busy while applying", 32'(busy), 1);
      for (int i = 0; i < N; i++) begin
        chk(mut_a[i*K +: K] == a, (sa == 0) ? "R3 zero seed a" : "R2 operand a", 32'(mut_a[i*K +: K]), 32'(a));
        chk(mut_b[i*K +: K] == b, (sb == 0) ? "R3 zero seed b" : "R2 operand b", 32'(mut_b[i*K +: K]), 32'(b));
      end
      if (p > flt_idx && flt_idx >= 0)
        chk(mismatch == 1'b1, "R6 sticky mismatch", 32'(mismatch), 1);
      flt   = (p == flt_idx);
      start = (p == mid_start);
      @(negedge clk);
      a = step(a);
      b = step(b);
    end
    flt = 1'b0; start = 1'b0;
    chk(busy == 1'b1 && sig_valid == 1'b0, "R7 check cycle", {busy, sig_valid}, 32'h2);
    chk(mismatch == exp_mis, "R6 mismatch before verdict", 32'(mismatch), 32'(exp_mis));
    @(negedge clk);
    for (int i = 0; i < K; i++) begin
      chk(sig_valid == 1'b1, "R8 valid during unload", 32'(sig_valid), 1);
      chk(sig_bit == fin[K-1-i], len == 0 ? "R4 zero length signature" : "R5 signature bit",
          32'(sig_bit), 32'(fin[K-1-i]));
      @(negedge clk);
    end
    for (int h = 0; h < 3; h++) begin
      chk(done == 1'b1 && busy == 1'b0 && sig_valid == 1'b0, "R9 done held", {done, busy, sig_valid}, 32'h4);
      chk(fail == (exp_mis || !good_exp), "R7 verdict", 32'(fail), 32'(exp_mis || !good_exp));
      chk(mismatch == exp_mis, "R9 mismatch held", 32'(mismatch), 32'(exp_mis));
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; test_en = 1'b0; start = 1'b0; flt = 1'b0;
    test_len = '0; seed_a = '0; seed_b = '0; misr_init = '0; expect_sig = '0;
    func_a = '0; func_b = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, mismatch, fail, sig_valid} == 5'b0, "R11 reset state",
        32'({busy, done, mismatch, fail, sig_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, mismatch, fail, sig_valid} == 5'b0, "R11 idle after reset",
        32'({busy, done, mismatch, fail, sig_valid}), 0);

    // R1 bypass sweep
    for (int v = 0; v < 256; v += 7) begin
      func_a = {8'(v), 8'(v ^ 8'h5A), 8'(255 - v)};
      func_b = {8'(v * 3), 8'(v + 1), 8'(v ^ 8'hC3)};
      #1;
      chk(mut_a == func_a && mut_b == func_b, "R1 bypass", mut_a, func_a);
      @(negedge clk);
    end

    test_en = 1'b1;
    // Near-exhaustive length sweep with assorted seeds
    for (int len = 0; len <= 24; len++)
      run(len, 8'(8'h11 * (len % 15) + 3), 8'(8'hA5 ^ len), 8'(len * 9), 1'b1, -1, -1);
    // Zero seeds (R3)
    run(10, 8'h00, 8'h00, 8'h7E, 1'b1, -1, -1);
    run(5, 8'h00, 8'h42, 8'h00, 1'b1, -1, -1);
    // Wrong expected signature, no disagreement (R7)
    run(12, 8'h35, 8'h9C, 8'h21, 1'b0, -1, -1);
    // Single-cycle fault, sticky flag, signature intact (R6, R7)
    run(16, 8'h81, 8'h18, 8'h00, 1'b1, 3, -1);
    run(16, 8'h81, 8'h18, 8'h00, 1'b1, 15, -1);
    // Next session clears the flag
    run(8, 8'h6B, 8'hD2, 8'h44, 1'b1, -1, -1);
    // Start during a run is ignored (R10)
    run(20, 8'h13, 8'h37, 8'h59, 1'b1, -1, 6);
    run(20, 8'h13, 8'h37, 8'h59, 1'b1, 9, 12);
    // Long length near counter use
    run(300, 8'hF0, 8'h0F, 8'hAA, 1'b1, -1, -1);

    test_en = 1'b0;
    func_a = 24'h123456; func_b = 24'hABCDEF;
    #1;
    chk(mut_a == func_a && mut_b == func_b, "R1 bypass after tests", mut_a, func_a);
    summary();
  end
endmodule